// File: doc/BRIEF.md
# Switchable Fixed/Rotating Channel Bus Arbiter

This block decides which of several transfer channels owns a shared bus. Each channel raises a request line. When the bus is free, the arbiter picks one requester, registers a one-hot grant and the winner's index, and asserts a hold towards the CPU. It keeps that grant until the channel reports that its transfer unit is done.

A runtime mode input selects one of two priority schemes. In fixed priority the lowest-numbered requester wins. In rotating priority the channel that most recently finished a transfer moves to the bottom of the order.

Two gating inputs control when a new grant may be issued. The first lets the CPU finish a read-modify-write before the bus is taken from it, or lets the grant preempt that operation. The second is a global abort: while it is enabled and a non-maskable interrupt is being handled, any grant in progress is dropped and no new grant is issued.

Top module: `chan_bus_arbiter`

## Requirements
- R1: After reset no grant is active: `grant` is 0, `grant_idx` is 0 and `cpu_hold` is 0. The rotation pointer is set so that channel 0 has the highest priority.
- R2: With `rr_mode`=0 and no grant active, the lowest-numbered requesting channel is granted at the next clock edge.
- R3: With `rr_mode`=1, the search starts at the channel one above the last channel that completed a transfer in rotating mode, and wraps from NUM_CH-1 to 0. The first requester found in that order wins.
- R4: The rotation pointer advances only when a grant completes (`xfer_done` while granted) with `rr_mode`=1. Grants that complete in fixed mode leave it unchanged, and so do cancelled grants. Returning to rotating mode resumes from the stored position.
- R5: An active grant and its index stay unchanged until `xfer_done` is sampled high. The grant is then released at that edge, and no new grant is issued at the same edge.
- R6: `grant` has at most one bit set. That bit is bit `grant_idx`, and `cpu_hold` is 1 exactly when a bit of `grant` is set.
- R7: With `rmw_wait`=1 and `cpu_rmw_busy`=1, no new grant is issued. A grant that is already active is not affected.
- R8: With `rmw_wait`=0, a new grant is issued whatever the value of `cpu_rmw_busy`.
- R9: With `abort_en`=1 and `nmi_active`=1, an active grant is dropped at the next edge, and no new grant is issued while both stay high.
- R10: With `abort_en`=0, `nmi_active` has no effect on grants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | NUM_CH | Per-channel request lines |
| rr_mode | input | 1 | 1 = rotating priority, 0 = fixed priority |
| rmw_wait | input | 1 | 1 = defer new grants while the CPU is in a read-modify-write |
| cpu_rmw_busy | input | 1 | CPU is in the middle of a read-modify-write |
| abort_en | input | 1 | Lets a non-maskable interrupt cancel and block grants |
| nmi_active | input | 1 | A non-maskable interrupt is being handled |
| xfer_done | input | 1 | The granted channel has finished its transfer unit |
| grant | output | NUM_CH | One-hot grant |
| grant_idx | output | $clog2(NUM_CH) | Index of the granted channel (holds its last value when idle) |
| cpu_hold | output | 1 | CPU is held off the bus because a grant is active |

## Verification
The bench builds the block with its default NUM_CH of 8, so the index is three bits wide. This default lets the rotating search wrap from channel 7 back to channel 0, and lets an all-ones request word show the full rotation order. Directed sequences place the rotation pointer at known positions. They then switch modes, cancel grants and defer grants, and check that the pointer is kept correctly in each case. A long random phase mixes every gating input and both modes against a reference model computed in the bench.

// File: rtl/arb_pkg.sv
package arb_pkg;
   localparam int ARB_DEF_CH = 8;

   // (a + b) mod n for 0 <= a,b < n
   function automatic int wrap_add(input int a, input int b, input int n);
      int s;
      s = a + b;
      if (s >= n) s = s - n;
      return s;
   endfunction
endpackage

// File: rtl/arb_pick.sv
module arb_pick
   import arb_pkg::*;
#(
   parameter int NUM_CH = ARB_DEF_CH,
   localparam int IDX_W = $clog2(NUM_CH)
)(
   input  logic [NUM_CH-1:0] req,
   input  logic [IDX_W-1:0]  base,
   output logic              hit,
   output logic [IDX_W-1:0]  idx
);
   always_comb begin
      hit = 1'b0;
      idx = '0;
      for (int k = 0; k < NUM_CH; k++) begin
         int c;
         c = wrap_add(int'(base), k, NUM_CH);
         if (!hit && req[c]) begin
            hit = 1'b1;
            idx = IDX_W'(c);
         end
      end
   end
endmodule

// File: rtl/arb_rotor.sv
module arb_rotor
   import arb_pkg::*;
#(
   parameter int NUM_CH = ARB_DEF_CH,
   localparam int IDX_W = $clog2(NUM_CH)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic [IDX_W-1:0] last,
   output logic [IDX_W-1:0] ptr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ptr <= '0;
      else if (adv) ptr <= IDX_W'(wrap_add(int'(last), 1, NUM_CH));
   end
endmodule

// File: rtl/chan_bus_arbiter.sv
module chan_bus_arbiter
   import arb_pkg::*;
#(
   parameter int NUM_CH = ARB_DEF_CH,
   localparam int IDX_W = $clog2(NUM_CH)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] req,
   input  logic              rr_mode,
   input  logic              rmw_wait,
   input  logic              cpu_rmw_busy,
   input  logic              abort_en,
   input  logic              nmi_active,
   input  logic              xfer_done,
   output logic [NUM_CH-1:0] grant,
   output logic [IDX_W-1:0]  grant_idx,
   output logic              cpu_hold
);
   generate
      if (NUM_CH < 2) begin : g_bad_count
         $error("chan_bus_arbiter: NUM_CH must be at least 2");
      end
   endgenerate

   logic             gnt_vld;
   logic [IDX_W-1:0] gnt_idx;
   logic [IDX_W-1:0] rot_ptr;
   logic [IDX_W-1:0] pick_base;
   logic             pick_hit;
   logic [IDX_W-1:0] pick_idx;
   logic             cancel;
   logic             issue_ok;
   logic             complete;

   assign cancel    = abort_en && nmi_active;
   assign issue_ok  = !cancel && !(rmw_wait && cpu_rmw_busy);
   assign complete  = gnt_vld && xfer_done && !cancel;
   assign pick_base = rr_mode ? rot_ptr : '0;

   arb_pick #(.NUM_CH(NUM_CH)) u_pick (
      .req  (req),
      .base (pick_base),
      .hit  (pick_hit),
      .idx  (pick_idx)
   );

   arb_rotor #(.NUM_CH(NUM_CH)) u_rotor (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (complete && rr_mode),
      .last  (gnt_idx),
      .ptr   (rot_ptr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gnt_vld <= 1'b0;
         gnt_idx <= '0;
      end else if (cancel) begin
         gnt_vld <= 1'b0;
      end else if (complete) begin
         gnt_vld <= 1'b0;
      end else if (!gnt_vld && issue_ok && pick_hit) begin
         gnt_vld <= 1'b1;
         gnt_idx <= pick_idx;
      end
   end

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_onehot
         assign grant[i] = gnt_vld && (gnt_idx == IDX_W'(i));
      end
   endgenerate

   assign grant_idx = gnt_idx;
   assign cpu_hold  = gnt_vld;
endmodule

// File: rtl/chan_bus_arbiter_chk.sv
module chan_bus_arbiter_chk #(
   parameter int NUM_CH = 8,
   localparam int IDX_W = $clog2(NUM_CH)
)(
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CH-1:0] req,
   input logic              rr_mode,
   input logic              rmw_wait,
   input logic              cpu_rmw_busy,
   input logic              abort_en,
   input logic              nmi_active,
   input logic              xfer_done,
   input logic [NUM_CH-1:0] grant,
   input logic [IDX_W-1:0]  grant_idx,
   input logic              cpu_hold
);
   AST_ONEHOT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R6
   AST_HOLD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_hold == (grant != '0)); // R6
   AST_GRANT_WAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_hold) |-> (($past(req) & grant) != '0)); // R2
   AST_FIXED_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cpu_hold) && $past(!rr_mode)) |-> (($past(req) & (grant - 1'b1)) == '0)); // R2
   AST_GRANT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_hold && !xfer_done && !(abort_en && nmi_active)) |=> (cpu_hold && $stable(grant_idx))); // R5
   AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_hold && xfer_done) |=> !cpu_hold); // R5
   AST_RMW_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_hold && rmw_wait && cpu_rmw_busy) |=> !cpu_hold); // R7
   AST_NMI_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_en && nmi_active) |=> !cpu_hold); // R9
endmodule

bind chan_bus_arbiter chan_bus_arbiter_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk(clk), .rst_n(rst_n), .req(req), .rr_mode(rr_mode), .rmw_wait(rmw_wait),
   .cpu_rmw_busy(cpu_rmw_busy), .abort_en(abort_en), .nmi_active(nmi_active),
   .xfer_done(xfer_done), .grant(grant), .grant_idx(grant_idx), .cpu_hold(cpu_hold)
);

// File: tb/chan_bus_arbiter_tb_top.sv
module chan_bus_arbiter_tb_top;
   localparam int N = 8;
   localparam int W = 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] req = '0;
   logic         rr_mode = 1'b0, rmw_wait = 1'b0, cpu_rmw_busy = 1'b0;
   logic         abort_en = 1'b0, nmi_active = 1'b0, xfer_done = 1'b0;
   logic [N-1:0] grant;
   logic [W-1:0] grant_idx;
   logic         cpu_hold;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   // reference model state
   bit       m_vld = 1'b0;
   int       m_idx = 0;
   int       m_ptr = 0;

   always #5 clk = ~clk;

   chan_bus_arbiter #(.NUM_CH(N)) dut_i (
      .clk(clk), .rst_n(rst_n), .req(req), .rr_mode(rr_mode), .rmw_wait(rmw_wait),
      .cpu_rmw_busy(cpu_rmw_busy), .abort_en(abort_en), .nmi_active(nmi_active),
      .xfer_done(xfer_done), .grant(grant), .grant_idx(grant_idx), .cpu_hold(cpu_hold)
   );

   function automatic int ref_pick(input logic [N-1:0] r, input int start);
      for (int k = 0; k < N; k++) begin
         if (r[(start + k) % N]) return (start + k) % N;
      end
      return -1;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // advance one clock: update model at the edge, compare at the falling edge
   task automatic cyc();
      int p;
      @(posedge clk);
      if (!rst_n) begin
         m_vld = 0; m_idx = 0; m_ptr = 0;
      end else if (abort_en && nmi_active) begin
         m_vld = 0;
      end else if (m_vld && xfer_done) begin
         if (rr_mode) m_ptr = (m_idx + 1) % N;
         m_vld = 0;
      end else if (!m_vld && !(rmw_wait && cpu_rmw_busy)) begin
         p = ref_pick(req, rr_mode ? m_ptr : 0);
         if (p >= 0) begin m_vld = 1; m_idx = p; end
      end
      @(negedge clk);
      chk("R6 grant vs model", int'(grant), m_vld ? (1 << m_idx) : 0);
      chk("R6 grant_idx vs model", int'(grant_idx), m_idx);
      chk("R6 cpu_hold vs model", int'(cpu_hold), int'(m_vld));
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=expired expected=done");
      finish_run();
   end

   initial begin
      void'($urandom(32'h00c0ffee));
      repeat (3) cyc();
      chk("R1 reset grant", int'(grant), 0);
      chk("R1 reset idx", int'(grant_idx), 0);
      chk("R1 reset hold", int'(cpu_hold), 0);
      rst_n = 1'b1;

      // R2 fixed priority
      req = 8'b1010_0100; cyc();
      chk("R2 lowest wins", int'(grant_idx), 2);
      xfer_done = 1'b1; cyc();
      chk("R5 released", int'(cpu_hold), 0);
      xfer_done = 1'b0; cyc();
      chk("R2 regrant", int'(grant_idx), 2);
      req = 8'h01; repeat (3) cyc();
      chk("R5 held stable", int'(grant_idx), 2);
      xfer_done = 1'b1; cyc(); xfer_done = 1'b0;

      // R1 pointer at reset, R3 rotation
      req = '0; cyc();
      rr_mode = 1'b1; req = 8'hFF; cyc();
      chk("R1 ptr starts at 0", int'(grant_idx), 0);
      xfer_done = 1'b1; cyc(); xfer_done = 1'b0; cyc();
      chk("R3 rotate to 1", int'(grant_idx), 1);
      xfer_done = 1'b1; req = 8'h03; cyc(); xfer_done = 1'b0; cyc();
      chk("R3 wrap to 0", int'(grant_idx), 0);
      xfer_done = 1'b1; cyc(); xfer_done = 1'b0;

      // R4 fixed mode leaves pointer (now 1)
      rr_mode = 1'b0; req = 8'hFF; cyc();
      chk("R4 fixed picks 0", int'(grant_idx), 0);
      xfer_done = 1'b1; cyc(); xfer_done = 1'b0;
      rr_mode = 1'b1; cyc();
      chk("R4 pointer kept", int'(grant_idx), 1);
      xfer_done = 1'b1; cyc(); xfer_done = 1'b0; req = '0; cyc();

      // R7 deferral (pointer 2)
      rmw_wait = 1'b1; cpu_rmw_busy = 1'b1; req = 8'h10; cyc(); cyc();
      chk("R7 deferred", int'(cpu_hold), 0);
      cpu_rmw_busy = 1'b0; cyc();
      chk("R7 after rmw", int'(grant_idx), 4);
      cpu_rmw_busy = 1'b1; cyc();
      chk("R7 active grant kept", int'(cpu_hold), 1);
      xfer_done = 1'b1; cyc(); xfer_done = 1'b0;

      // R8 preempt (pointer 5)
      rmw_wait = 1'b0; req = 8'h08; cyc();
      chk("R8 preempts rmw", int'(grant_idx), 3);
      xfer_done = 1'b1; cyc(); xfer_done = 1'b0; cpu_rmw_busy = 1'b0;

      // R9 abort (pointer 4)
      abort_en = 1'b1; req = 8'h40; cyc();
      chk("R9 granted before nmi", int'(grant_idx), 6);
      nmi_active = 1'b1; cyc();
      chk("R9 cancelled", int'(cpu_hold), 0);
      cyc(); cyc();
      chk("R9 blocked", int'(cpu_hold), 0);
      nmi_active = 1'b0; req = 8'hFF; cyc();
      chk("R4 cancel keeps pointer", int'(grant_idx), 4);
      xfer_done = 1'b1; cyc(); xfer_done = 1'b0;

      // R10 nmi ignored
      abort_en = 1'b0; nmi_active = 1'b1; req = 8'h02; cyc(); cyc();
      chk("R10 nmi ignored", int'(grant_idx), 1);
      chk("R10 still held", int'(cpu_hold), 1);
      xfer_done = 1'b1; cyc(); xfer_done = 1'b0; nmi_active = 1'b0;

      // random phase against the model (R2..R10)
      for (int i = 0; i < 3000; i++) begin
         req          = N'($urandom);
         xfer_done    = ($urandom % 3) == 0;
         if (($urandom % 16) == 0) rr_mode = ~rr_mode;
         rmw_wait     = ($urandom % 4) == 0;
         cpu_rmw_busy = ($urandom % 3) == 0;
         abort_en     = ($urandom % 4) == 0;
         nmi_active   = ($urandom % 5) == 0;
         cyc();
      end
      finish_run();
   end
endmodule